// File: doc/BRIEF.md
# Programmable Frame-Sync Pulse Generator

This block produces a repeating frame-synchronization pulse for a serial port. It is paced by a one-clock-wide enable, `tick`, that marks each period of the generator clock. Two fields set the shape of the pulse: `period_m1` holds the frame length in ticks minus one, and `width_m1` holds the active pulse length in ticks minus one. A frame-start strobe marks the tick on which each new frame begins.

Generation runs only while the generator is enabled (`gen_en`) and the free-running sync mode (`free_run`) is selected. If either input drops, the output returns to its idle low state at once. The next enabled tick then starts a fresh frame.

The implementation uses two down-counters that reload together at each frame boundary and count down on the same ticks. The width counter ends the active phase when it reaches zero. The period counter starts the next frame when it reaches zero.

Top module: `fsg_frame_sync`

## Requirements
- R1: While reset is applied, and on the clock cycle after either `gen_en` or `free_run` is seen low, `fsync` and `frame_start` are both 0.
- R2: No frame starts unless `gen_en` and `free_run` are both 1. With one of them 0, `fsync` stays 0 however many ticks arrive.
- R3: `fsync` is high for `width_m1`+1 consecutive ticks at the start of each frame. `width_m1` is 8 bits wide, so the active width is 1 to 256 ticks.
- R4: A new frame begins every `period_m1`+1 ticks. `period_m1` is 12 bits wide, so the frame length is 1 to 4096 ticks.
- R5: The first tick after generation is enabled starts a frame. On that tick `fsync` goes high.
- R6: When `width_m1` >= `period_m1`, `fsync` stays high for the whole frame and does not drop between frames.
- R7: `period_m1` and `width_m1` are sampled only on the tick that starts a frame. A change partway through a frame first takes effect at the next frame.
- R8: Counters and outputs change only on clock cycles with `tick` = 1, except for the clearing described in R1. Between ticks, `fsync` holds its value.
- R9: With the default strobe variant, `frame_start` is 1 for exactly the one generator period that begins each frame. Whenever it is 1, `fsync` is also 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock enable marking each generator clock period |
| gen_en | input | 1 | Generator enable (release of the generator from reset) |
| free_run | input | 1 | Selects free-running frame-sync generation |
| width_m1 | input | 8 | Active pulse width in ticks, minus one |
| period_m1 | input | 12 | Frame period in ticks, minus one |
| fsync | output | 1 | Frame-synchronization output |
| frame_start | output | 1 | Marks the generator period that begins a frame |

## Verification
The generator is driven with several period and width pairs:
- The 16/2 shape tests the ordinary case where the width is much shorter than the period.
- A width of 1 tests the shortest pulse.
- Widths equal to and larger than the period test the case where the output saturates high.
- A period of 1 makes every tick a frame start.
- The 256/4096 extreme pair catches counters that are truncated or off by one at full field width.

A mid-frame field change distinguishes fields that are sampled at the frame boundary from fields that are read live. Runs with only one of the two enables set, and a disable partway through a frame, separate the gating and clearing behaviour from normal generation. Every tick is followed by an idle clock on which the outputs must hold, which exposes logic that advances without a tick.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

   // How the frame-start strobe is timed.
   typedef enum logic [0:0] {
      STRB_TICK = 1'b0,   // held for the whole generator period that begins a frame
      STRB_CLK  = 1'b1    // a single system-clock pulse on the start tick
   } strobe_mode_e;

   localparam int unsigned FSG_WID_W_DEF = 8;
   localparam int unsigned FSG_PER_W_DEF = 12;

endpackage

// File: rtl/fsg_dcount.sv
module fsg_dcount #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic         dec,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count,
   output logic         zero
);

   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (load)
         count <= load_val;
      else if (dec)
         count <= count - ONE;
   end

   assign zero = (count == '0);

endmodule

// File: rtl/fsg_seq.sv
module fsg_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   input  logic per_zero,
   input  logic wid_zero,
   output logic start,
   output logic step,
   output logic fsync
);

   logic running;

   // A frame starts on the first enabled tick, or on the tick after the
   // period count has run out. Every other enabled tick is a step.
   assign start = tick & run & (~running | per_zero);
   assign step  = tick & run & running & ~per_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         fsync   <= 1'b0;
      end else if (!run) begin
         running <= 1'b0;
         fsync   <= 1'b0;
      end else if (start) begin
         running <= 1'b1;
         fsync   <= 1'b1;
      end else if (step && wid_zero) begin
         fsync   <= 1'b0;
      end
   end

endmodule

// File: rtl/fsg_frame_sync.sv
module fsg_frame_sync
   import fsg_pkg::*;
#(
   parameter int unsigned  WID_W  = FSG_WID_W_DEF,
   parameter int unsigned  PER_W  = FSG_PER_W_DEF,
   parameter strobe_mode_e STROBE = STRB_TICK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             gen_en,
   input  logic             free_run,
   input  logic [WID_W-1:0] width_m1,
   input  logic [PER_W-1:0] period_m1,
   output logic             fsync,
   output logic             frame_start
);

   // Elaboration-time parameter checks.
   if (WID_W < 1 || WID_W > 16) begin : g_bad_wid_w
      $error("fsg_frame_sync: WID_W must be in 1..16");
   end
   if (PER_W < 1 || PER_W > 24) begin : g_bad_per_w
      $error("fsg_frame_sync: PER_W must be in 1..24");
   end

   logic             run;
   logic             start;
   logic             step;
   logic             per_zero;
   logic             wid_zero;
   logic [PER_W-1:0] per_cnt;
   logic [WID_W-1:0] wid_cnt;
   logic             strb_q;

   assign run = gen_en & free_run;

   fsg_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .run      (run),
      .per_zero (per_zero),
      .wid_zero (wid_zero),
      .start    (start),
      .step     (step),
      .fsync    (fsync)
   );

   // Both counters load together on the start tick and count down on the same steps.
   fsg_dcount #(.W(PER_W)) u_per_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (~run),
      .load     (start),
      .dec      (step),
      .load_val (period_m1),
      .count    (per_cnt),
      .zero     (per_zero)
   );

   // The width counter stops at zero so that a long width saturates.
   fsg_dcount #(.W(WID_W)) u_wid_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (~run),
      .load     (start),
      .dec      (step & ~wid_zero),
      .load_val (width_m1),
      .count    (wid_cnt),
      .zero     (wid_zero)
   );

   if (STROBE == STRB_TICK) begin : g_strb_tick
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            strb_q <= 1'b0;
         else if (!run)
            strb_q <= 1'b0;
         else if (tick)
            strb_q <= start;
      end
   end else begin : g_strb_clk
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            strb_q <= 1'b0;
         else
            strb_q <= start;
      end
   end

   assign frame_start = strb_q;

   // The counter values are internal state; only their zero flags drive logic.
   logic unused_cnt;
   assign unused_cnt = ^{per_cnt, wid_cnt};

endmodule

// File: rtl/fsg_frame_sync_chk.sv
module fsg_frame_sync_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic gen_en,
   input logic free_run,
   input logic fsync,
   input logic frame_start
);

   // R1: dropping either enable clears both outputs on the next clock.
   assert_off_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(gen_en && free_run) |=> (!fsync && !frame_start));

   // R2, R5: fsync rises only after an enabled tick.
   assert_rise_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsync) |-> $past(tick && gen_en && free_run));

   // R8: with no tick and generation enabled, fsync holds.
   assert_hold_between_ticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && gen_en && free_run) |=> $stable(fsync));

   // R9: the strobe is only ever seen while fsync is active.
   assert_strobe_in_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> fsync);

   // R9: every rising edge of fsync is marked as a frame start.
   assert_rise_marks_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsync) |-> frame_start);

endmodule

bind fsg_frame_sync fsg_frame_sync_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .gen_en      (gen_en),
   .free_run    (free_run),
   .fsync       (fsync),
   .frame_start (frame_start)
);

// File: tb/fsg_frame_sync_bench.sv
module fsg_frame_sync_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        gen_en = 1'b0;
   logic        free_run = 1'b0;
   logic [7:0]  width_m1 = '0;
   logic [11:0] period_m1 = '0;
   logic        fsync;
   logic        frame_start;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   fsg_frame_sync u_fsg_frame_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .gen_en      (gen_en),
      .free_run    (free_run),
      .width_m1    (width_m1),
      .period_m1   (period_m1),
      .fsync       (fsync),
      .frame_start (frame_start)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // One tick, then one idle clock on which the outputs must hold.
   // Both outputs are sampled at negedges, after the edge that used the tick.
   task automatic do_tick(output logic fs, output logic st, output bit held);
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      fs = fsync;
      st = frame_start;
      @(negedge clk);
      held = (fsync == fs) && (frame_start == st);
   endtask

   // Run n ticks with fields (pa, wa); at tick index chg the fields switch to (pb, wb).
   // Expected values come from a frame-position model that latches the fields at
   // each frame start.
   task automatic run_pattern(input string req, input int n, input int pa, input int wa,
                              input int chg, input int pb, input int wb);
      int pos = 0, curp = 0, curw = 0;
      int fs_err = 0, st_err = 0, hold_err = 0;
      int fs_act = 0, fs_exp = 0, st_act = 0, st_exp = 0;
      logic fs, st;
      bit held;
      @(negedge clk);
      period_m1 = 12'(pa);
      width_m1  = 8'(wa);
      gen_en    = 1'b1;
      free_run  = 1'b1;
      for (int i = 0; i < n; i++) begin
         if (i == chg) begin
            period_m1 = 12'(pb);
            width_m1  = 8'(wb);
         end
         if (pos == 0) begin
            curp = int'(period_m1);
            curw = int'(width_m1);
         end
         do_tick(fs, st, held);
         if (fs !== (pos <= curw)) begin
            if (fs_err == 0) begin fs_act = int'(fs); fs_exp = int'(pos <= curw); end
            fs_err++;
         end
         if (st !== (pos == 0)) begin
            if (st_err == 0) begin st_act = int'(st); st_exp = int'(pos == 0); end
            st_err++;
         end
         if (!held) hold_err++;
         pos = (pos >= curp) ? 0 : pos + 1;
      end
      check(fs_err == 0, req, "fsync pattern (first mismatch)", fs_act, fs_exp);
      check(st_err == 0, {req, " R9"}, "frame_start pattern (first mismatch)", st_act, st_exp);
      check(hold_err == 0, "R8", "outputs changed between ticks (count)", hold_err, 0);
      // R1: dropping the mode select clears the outputs on the next clock.
      free_run = 1'b0;
      @(negedge clk);
      check(!fsync && !frame_start, "R1", "outputs after disable", int'({fsync, frame_start}), 0);
   endtask

   task automatic test_reset();
      check(fsync === 1'b0, "R1", "fsync in reset", int'(fsync), 0);
      check(frame_start === 1'b0, "R1", "frame_start in reset", int'(frame_start), 0);
   endtask

   // R2: only one of the two enables set, ticks arrive, nothing starts.
   task automatic test_gating(input bit en, input bit fr);
      int hits = 0;
      logic fs, st;
      bit held;
      @(negedge clk);
      period_m1 = 12'd3;
      width_m1  = 8'd1;
      gen_en    = en;
      free_run  = fr;
      for (int i = 0; i < 10; i++) begin
         do_tick(fs, st, held);
         if (fs || st) hits++;
      end
      check(hits == 0, "R2", "ticks with output high while gated", hits, 0);
      gen_en   = 1'b0;
      free_run = 1'b0;
   endtask

   // R1, R5: disable partway through a frame, then re-enable; a fresh frame follows.
   task automatic test_midframe_disable();
      logic fs, st;
      bit held;
      @(negedge clk);
      period_m1 = 12'd9;
      width_m1  = 8'd5;
      gen_en    = 1'b1;
      free_run  = 1'b1;
      for (int i = 0; i < 3; i++) do_tick(fs, st, held);
      gen_en = 1'b0;
      @(negedge clk);
      check(!fsync, "R1", "fsync after gen_en drop mid-frame", int'(fsync), 0);
      run_pattern("R5", 12, 9, 5, -1, 0, 0);
      gen_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      check(!fsync && !frame_start, "R1", "idle after reset release", int'({fsync, frame_start}), 0);
      test_gating(1'b1, 1'b0);
      test_gating(1'b0, 1'b1);
      run_pattern("R3 R4 R5", 48, 15, 1, -1, 0, 0);    // 16-tick frame, 2-tick pulse
      run_pattern("R3 R4", 24, 7, 0, -1, 0, 0);        // shortest pulse
      run_pattern("R6", 30, 5, 20, -1, 0, 0);          // width beyond period
      run_pattern("R6", 30, 9, 9, -1, 0, 0);           // width equal to period
      run_pattern("R4 R6", 8, 0, 0, -1, 0, 0);         // one-tick frame
      run_pattern("R7", 30, 7, 2, 3, 3, 0);            // fields change mid-frame
      run_pattern("R3 R4", 8200, 4095, 255, -1, 0, 0); // extreme widths
      test_midframe_disable();
      done = 1'b1;
      summary();
      $finish;
   end

endmodule